// File: doc/BRIEF.md
# Fault Status Capture Register

This block watches three external fault lines of a motor-control PWM generator and reports them through one status word on a simple single-cycle register bus. Each raw line is first brought into the block clock domain by a two-stage synchronizer. It is then XORed with a programmable polarity bit, so that a line that is active when low reads as active-high.

One mode bit selects how the status word behaves:

- **Live mode.** The status bits are read-only and track the polarity-adjusted lines.
- **Latched mode.** Each bit becomes a sticky flag. It sets when its adjusted line is active and stays set until software writes a one to it.

Software usually runs in latched mode so that short fault pulses are not missed. It polls the status word and acknowledges each flag with a write-one-to-clear. Returning to live mode throws away any flags still held.

Top module: `fault_status_reg`

## Requirements
- R1: Fault line i is reported at bit i of the status word (i = 0, 1, 2). Bits 31 to 3 of every read are zero.
- R2: After reset, the mode register, the polarity register and the status word all read 0.
- R3: In live mode (mode bit 0 = 0), status bit i equals raw line i XOR polarity bit i. The value is readable within two clock edges of a line change.
- R4: In latched mode (mode bit 0 = 1), status bit i becomes 1 once its adjusted line has been active. It stays 1 after the line returns to inactive. A bit whose adjusted line has not been active since the last clear reads 0.
- R5: In latched mode, writing 1 to status bit i clears it, and writing 0 leaves it unchanged.
- R6: If a write-one-to-clear arrives in the same cycle that the adjusted line is active, the bit stays 1.
- R7: In live mode, writes to the status word have no effect.
- R8: Leaving latched mode discards all held flags. The read value follows the live lines from the next cycle, and re-entering latched mode starts with every flag clear.
- R9: The register map is as follows:
  - byte address 0x0 holds the mode bit at bit 0;
  - byte address 0x4 holds the polarity bits at bits 2:0, where 1 means active-low;
  - byte address 0x8 holds the status word.

  Mode and polarity read back as written, with their unused bits zero. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fault_raw_i | input | 3 | Raw asynchronous fault lines |
| bus_addr_i | input | 4 | Register byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |

## Verification
The hardest case is a clear and an active line arriving on the same clock edge. It needs the flag already set and the line still held active while the write lands, so the bench keeps the line asserted across the write and reads back on the very next cycle. Discarding flags on a mode change is also reached only through a set sequence: capture flags, drop the lines, switch to live, then return to latched and confirm that nothing survived.

// File: rtl/flt_stat_pkg.sv
package flt_stat_pkg;
  localparam int unsigned BUS_ADDR_W = 4;

  typedef enum logic [BUS_ADDR_W-1:0] {
    SEL_MODE     = 4'h0,
    SEL_POLARITY = 4'h4,
    SEL_STATUS   = 4'h8
  } reg_sel_e;
endpackage

// File: rtl/flt_rst_sync.sv
module flt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/flt_sync.sv
module flt_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = raw_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/flt_capture.sv
module flt_capture #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_i,
  input  logic [WIDTH-1:0] polarity_i,
  input  logic             hold_en_i,
  input  logic [WIDTH-1:0] ack_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] active;
  logic [WIDTH-1:0] flag_d, flag_q;

  assign active = line_i ^ polarity_i;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
        if (!hold_en_i)   flag_d[i] = 1'b0;
        else if (active[i]) flag_d[i] = 1'b1;
        else if (ack_i[i])  flag_d[i] = 1'b0;
        else                flag_d[i] = flag_q[i];
      end

      assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en_i && active[i]) |=> (flag_q[i] || !hold_en_i));

      assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en_i && flag_q[i] && !ack_i[i]) |=> (flag_q[i] || !hold_en_i));

      assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en_i && ack_i[i] && !active[i]) |=> !flag_q[i]);

      assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en_i && ack_i[i] && active[i]) |=> (flag_q[i] || !hold_en_i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign status_o = hold_en_i ? flag_q : active;

  assert_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en_i |=> (flag_q == '0));
endmodule

// File: rtl/flt_regif.sv
module flt_regif
  import flt_stat_pkg::*;
#(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BUS_ADDR_W-1:0] addr_i,
  input  logic                  wr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [WIDTH-1:0]      status_i,
  output logic                  hold_en_o,
  output logic [WIDTH-1:0]      polarity_o,
  output logic [WIDTH-1:0]      ack_o
);
  logic             hold_q, hold_d, hold_we;
  logic [WIDTH-1:0] pol_q, pol_d;
  logic             pol_we;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:WIDTH];

  assign hold_we = wr_i && (addr_i == SEL_MODE);
  assign pol_we  = wr_i && (addr_i == SEL_POLARITY);
  assign hold_d  = hold_we ? wdata_i[0] : hold_q;
  assign pol_d   = pol_we ? wdata_i[WIDTH-1:0] : pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      pol_q  <= '0;
    end else begin
      hold_q <= hold_d;
      pol_q  <= pol_d;
    end
  end

  always_comb begin
    ack_o = '0;
    if (wr_i && (addr_i == SEL_STATUS) && hold_q) ack_o = wdata_i[WIDTH-1:0];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      SEL_MODE:     rdata_o[0]       = hold_q;
      SEL_POLARITY: rdata_o[WIDTH-1:0] = pol_q;
      SEL_STATUS:   rdata_o[WIDTH-1:0] = status_i;
      default:      rdata_o          = '0;
    endcase
  end

  assign hold_en_o  = hold_q;
  assign polarity_o = pol_q;

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[DATA_W-1:WIDTH] == '0);

  assert_live_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |-> (ack_o == '0));
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import flt_stat_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 3,
  parameter int unsigned SYNC_DEPTH  = 2,
  parameter int unsigned RST_DEPTH   = 2,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  fault_raw_i,
  input  logic [BUS_ADDR_W-1:0] bus_addr_i,
  input  logic                  bus_wr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o
);
  logic                 rst_n;
  logic [NUM_LINES-1:0] line_sync;
  logic [NUM_LINES-1:0] polarity;
  logic [NUM_LINES-1:0] ack;
  logic [NUM_LINES-1:0] status;
  logic                 hold_en;

  flt_rst_sync #(.STAGES(RST_DEPTH)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  flt_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (fault_raw_i),
    .sync_o (line_sync)
  );

  flt_capture #(.WIDTH(NUM_LINES)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (line_sync),
    .polarity_i (polarity),
    .hold_en_i  (hold_en),
    .ack_i      (ack),
    .status_o   (status)
  );

  flt_regif #(.WIDTH(NUM_LINES), .DATA_W(DATA_W)) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (bus_addr_i),
    .wr_i       (bus_wr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .status_i   (status),
    .hold_en_o  (hold_en),
    .polarity_o (polarity),
    .ack_o      (ack)
  );
endmodule

// File: tb/fault_status_reg_bench.sv
`timescale 1ns/1ps
module fault_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [2:0]  fault_raw;
  logic [3:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_MODE = 4'h0;
  localparam logic [3:0] A_POL  = 4'h4;
  localparam logic [3:0] A_STAT = 4'h8;

  always #10 clk = ~clk;

  fault_status_reg u_fault_status_reg (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .fault_raw_i (fault_raw),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_ni = 1'b0; fault_raw = '0; addr = '0; wr = 1'b0; wdata = '0;
    idle(3);
    rst_ni = 1'b1;
    idle(4);

    // R2: reset values
    reg_rd(A_MODE, r); check("R2 mode reset", r, 32'h0);
    reg_rd(A_POL, r);  check("R2 polarity reset", r, 32'h0);
    reg_rd(A_STAT, r); check("R2 status reset", r, 32'h0);

    // R9: readback of mode and polarity, unused bits zero, unmapped address
    reg_wr(A_POL, 32'hFFFF_FFFD);
    reg_rd(A_POL, r); check("R9 polarity readback", r, 32'h5);
    reg_wr(A_MODE, 32'hFFFF_FFFF);
    reg_rd(A_MODE, r); check("R9 mode readback", r, 32'h1);
    reg_rd(4'hC, r); check("R9 unmapped read", r, 32'h0);
    reg_wr(A_MODE, 32'h0);
    reg_wr(A_POL, 32'h0);

    // R3 / R1: live sweep over every polarity and line pattern
    for (int s = 0; s < 8; s++) begin
      reg_wr(A_POL, s);
      for (int p = 0; p < 8; p++) begin
        fault_raw = p[2:0];
        idle(3);
        reg_rd(A_STAT, r);
        check("R3 live status", r, {29'h0, p[2:0] ^ s[2:0]});
      end
    end
    fault_raw = '0;
    reg_wr(A_POL, 32'h0);
    idle(3);

    // R7: writes in live mode are ignored
    for (int p = 0; p < 8; p++) begin
      fault_raw = p[2:0];
      idle(3);
      reg_wr(A_STAT, 32'hFFFF_FFFF);
      reg_rd(A_STAT, r); check("R7 live write ignored", r, {29'h0, p[2:0]});
    end
    fault_raw = '0;
    idle(3);

    // R4 / R5 / R1: latched capture then partial acknowledge
    reg_wr(A_MODE, 32'h1);
    for (int p = 1; p < 8; p++) begin
      for (int m = 0; m < 8; m++) begin
        reg_wr(A_STAT, 32'h7);
        reg_rd(A_STAT, r); check("R5 clear all", r, 32'h0);
        fault_raw = p[2:0];
        idle(4);
        fault_raw = '0;
        idle(4);
        reg_rd(A_STAT, r); check("R4 sticky capture", r, {29'h0, p[2:0]});
        reg_wr(A_STAT, {29'h1FFF_FFFF, m[2:0]} & 32'hFFFF_FFF8 | m);
        reg_rd(A_STAT, r); check("R5 w1c mask", r, {29'h0, p[2:0] & ~m[2:0]});
      end
    end

    // R4: polarity applies in latched mode (active-low lines)
    reg_wr(A_POL, 32'h7);
    fault_raw = 3'b111;
    idle(4);
    reg_wr(A_STAT, 32'h7);
    idle(2);
    reg_rd(A_STAT, r); check("R4 inactive low lines no capture", r, 32'h0);
    fault_raw = 3'b110;
    idle(4);
    fault_raw = 3'b111;
    idle(4);
    reg_rd(A_STAT, r); check("R4 active-low capture", r, 32'h1);
    reg_wr(A_POL, 32'h0);
    fault_raw = '0;
    idle(4);
    reg_wr(A_STAT, 32'h7);

    // R6: clear arriving while line still active
    fault_raw = 3'b010;
    idle(4);
    reg_wr(A_STAT, 32'h2);
    reg_rd(A_STAT, r); check("R6 set wins over clear", r, 32'h2);
    fault_raw = '0;
    idle(4);
    reg_wr(A_STAT, 32'h2);
    reg_rd(A_STAT, r); check("R5 clear after release", r, 32'h0);

    // R8: leaving latched mode discards flags
    fault_raw = 3'b111;
    idle(4);
    fault_raw = '0;
    idle(4);
    reg_rd(A_STAT, r); check("R8 flags before switch", r, 32'h7);
    reg_wr(A_MODE, 32'h0);
    reg_rd(A_STAT, r); check("R8 live right after switch", r, 32'h0);
    reg_wr(A_MODE, 32'h1);
    idle(1);
    reg_rd(A_STAT, r); check("R8 flags discarded on return", r, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule